// File: doc/BRIEF.md
# Mirrored-Stripe Block Address Mapper

This block accepts one logical transfer request at a time: a starting logical block number, a byte count and a read/write direction. It cuts the transfer into single logical blocks, issued in ascending order from the starting block. For each block it works out where that block lives in an array whose primary disks are striped and whose copies sit on an equal set of mirror disks. Three configuration inputs describe the layout: the logical block size in bytes, the stripe depth in bytes, and the count of primary disks. They are captured when a request is accepted.

For every logical block the block produces one output beat. The beat carries the logical block number, the primary disk id, the block number on that disk and an end-of-request marker. A write beat also carries the mirror disk id, which uses the same disk block number. All divisions run on one shared multi-cycle iterative divider. The request side is held off from acceptance until the final beat of the current request has been taken. Output beats use a valid/ready handshake.

Top module: `mstripe_mapper`

## Requirements
- R1: A request produces ceil(len / block_bytes) beats, or exactly one beat when len is 0. The beats carry consecutive logical block numbers, starting at the start block and rising by one per beat.
- R2: `out_last` is 1 only on the final beat of a request. Once that beat is taken, `req_ready` is 1 on the next cycle.
- R3: Let D = stripe_bytes / block_bytes and N = primary disk count. The primary disk id is (lba mod (D*N)) / D.
- R4: The disk block number is (lba / (D*N)) * D + ((lba mod (D*N)) mod D). With 4096-byte blocks, a 16384-byte stripe and 3 disks, block 21 maps to disk 2, disk block 5.
- R5: On a write, `out_mir_en` is 1 and `out_mir_disk` equals the primary disk id plus N. The mirror uses the same disk block number, so block 21 in the example above has its copy on disk 5.
- R6: On a read, only the primary disk is addressed: `out_mir_en` is 0 and `out_mir_disk` is 0.
- R7: `req_ready` is 0 and `busy` is 1 from acceptance until the final beat is taken. A `req_valid` raised during that time is ignored and produces no beats. `out_valid` is never 1 while idle.
- R8: While `out_valid` is 1 and `out_ready` is 0, the beat stays valid and every output field holds its value.
- R9: The configuration inputs are sampled only when a request is accepted. Changing them while busy does not alter the beats of the request in progress.
- R10: After reset, `req_ready` is 1, `busy` is 0 and `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_blk_bytes | input | LEN_W | Logical block size in bytes |
| cfg_stripe_bytes | input | LEN_W | Stripe depth in bytes |
| cfg_ndisk | input | DISK_W | Number of primary disks |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_lba | input | LBA_W | Starting logical block |
| req_len | input | LEN_W | Transfer length in bytes |
| req_write | input | 1 | 1 = write, 0 = read |
| busy | output | 1 | A request is being split |
| out_valid | output | 1 | Beat available |
| out_ready | input | 1 | Beat taken when high together with out_valid |
| out_lba | output | LBA_W | Logical block of this beat |
| out_pri_disk | output | DISK_W+1 | Primary disk id |
| out_dblk | output | LBA_W | Block number on the disk |
| out_mir_en | output | 1 | Mirror copy addressed (writes) |
| out_mir_disk | output | DISK_W+1 | Mirror disk id |
| out_last | output | 1 | Final beat of the request |

## Verification
Each beat is due at a data-dependent time. It follows acceptance by two divisions of LBA_W+1 cycles for setup, then two more divisions per block. So the bench does not predict a cycle: it waits on `out_valid` at falling edges and compares all fields there. It then raises `out_ready` for exactly one rising edge. Effects that follow a handshake by exactly one cycle are sampled at the next falling edge: `req_ready` returning after the last beat, and the held beat under backpressure.

// File: rtl/msm_pkg.sv
`timescale 1ns/1ps
package msm_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_NBLK,
      ST_DEPTH,
      ST_STRIPE,
      ST_DISK,
      ST_EMIT
   } msm_state_e;
endpackage

// File: rtl/msm_divider.sv
`timescale 1ns/1ps
// Restoring radix-2 divider: one quotient bit per cycle, done pulses once.
module msm_divider #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic [W-1:0] dividend,
   input  logic [W-1:0] divisor,
   output logic         done,
   output logic [W-1:0] quot,
   output logic [W-1:0] rem
);
   localparam int CNT_W = $clog2(W + 1);

   generate
      if (W < 2) begin : g_bad_width
         $error("msm_divider: W must be at least 2");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;
   logic [W-1:0]     dvd_q, dsr_q;
   logic [W:0]       trial;
   logic             fits;

   assign trial = {rem, quot[W-1]};
   assign fits  = trial >= {1'b0, dsr_q};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         dvd_q <= '0;
         dsr_q <= '0;
         quot  <= '0;
         rem   <= '0;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         if (start) begin
            quot  <= dividend;
            rem   <= '0;
            dvd_q <= dividend;
            dsr_q <= divisor;
            cnt_q <= CNT_W'(W);
         end else if (cnt_q != '0) begin
            quot  <= {quot[W-2:0], fits};
            rem   <= fits ? W'(trial - {1'b0, dsr_q}) : trial[W-1:0];
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CNT_W'(1)) done <= 1'b1;
         end
      end
   end

   // R4: every finished division satisfies q*d + r == n with r < d
   a_r4_div_identity: assert property (@(posedge clk) disable iff (!rst_n)
      done && (dsr_q != '0) |->
         ((2*W)'(quot) * (2*W)'(dsr_q) + (2*W)'(rem) == (2*W)'(dvd_q)) && (rem < dsr_q));
endmodule

// File: rtl/msm_out_stage.sv
`timescale 1ns/1ps
// Output holding register with valid/ready handshake.
module msm_out_stage #(
   parameter int LBA_W = 32,
   parameter int DID_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [LBA_W-1:0] in_lba,
   input  logic [DID_W-1:0] in_pri,
   input  logic [LBA_W-1:0] in_dblk,
   input  logic             in_mir_en,
   input  logic [DID_W-1:0] in_mir,
   input  logic             in_last,
   input  logic             out_ready,
   output logic             out_valid,
   output logic [LBA_W-1:0] out_lba,
   output logic [DID_W-1:0] out_pri,
   output logic [LBA_W-1:0] out_dblk,
   output logic             out_mir_en,
   output logic [DID_W-1:0] out_mir,
   output logic             out_last,
   output logic             fire
);
   assign fire = out_valid & out_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         out_lba    <= '0;
         out_pri    <= '0;
         out_dblk   <= '0;
         out_mir_en <= 1'b0;
         out_mir    <= '0;
         out_last   <= 1'b0;
      end else if (load) begin
         out_valid  <= 1'b1;
         out_lba    <= in_lba;
         out_pri    <= in_pri;
         out_dblk   <= in_dblk;
         out_mir_en <= in_mir_en;
         out_mir    <= in_mir;
         out_last   <= in_last;
      end else if (fire) begin
         out_valid  <= 1'b0;
      end
   end

   // R8: a stalled beat keeps every field
   a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_lba) && $stable(out_pri)
         && $stable(out_dblk) && $stable(out_mir_en) && $stable(out_mir) && $stable(out_last));
endmodule

// File: rtl/mstripe_mapper.sv
`timescale 1ns/1ps
module mstripe_mapper
   import msm_pkg::*;
#(
   parameter int LBA_W    = 32,
   parameter int LEN_W    = 24,
   parameter int DISK_W   = 4,
   parameter bit LEN_CEIL = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [LEN_W-1:0]    cfg_blk_bytes,
   input  logic [LEN_W-1:0]    cfg_stripe_bytes,
   input  logic [DISK_W-1:0]   cfg_ndisk,
   input  logic                req_valid,
   output logic                req_ready,
   input  logic [LBA_W-1:0]    req_lba,
   input  logic [LEN_W-1:0]    req_len,
   input  logic                req_write,
   output logic                busy,
   output logic                out_valid,
   input  logic                out_ready,
   output logic [LBA_W-1:0]    out_lba,
   output logic [DISK_W:0]     out_pri_disk,
   output logic [LBA_W-1:0]    out_dblk,
   output logic                out_mir_en,
   output logic [DISK_W:0]     out_mir_disk,
   output logic                out_last
);
   localparam int DID_W = DISK_W + 1;
   localparam int DV_W  = LBA_W;

   generate
      if (LEN_W > LBA_W) begin : g_bad_len
         $error("mstripe_mapper: LEN_W must not exceed LBA_W");
      end
      if (DISK_W < 1) begin : g_bad_disk
         $error("mstripe_mapper: DISK_W must be at least 1");
      end
   endgenerate

   msm_state_e         state_q;
   logic               div_go_q, div_done;
   logic [DV_W-1:0]    div_dvd, div_dsr, div_quot, div_rem;
   logic [LBA_W-1:0]   lba_q, remain_q, depth_q, width_q, sidx_q, off_q;
   logic [LEN_W-1:0]   blk_q, sdep_q, len_q;
   logic [DISK_W-1:0]  nd_q;
   logic               wr_q;
   logic [DV_W-1:0]    nblk_dvd;
   logic               out_load, out_fire;
   logic [DID_W-1:0]   pri_id, mir_id;
   logic [LBA_W-1:0]   dblk_calc;

   // Block count: rounded up or truncated, chosen by parameter
   generate
      if (LEN_CEIL) begin : g_len_ceil
         assign nblk_dvd = DV_W'(len_q) + DV_W'(blk_q) - DV_W'(1);
      end else begin : g_len_floor
         assign nblk_dvd = DV_W'(len_q);
      end
   endgenerate

   always_comb begin
      div_dvd = '0;
      div_dsr = '0;
      case (state_q)
         ST_NBLK:   begin div_dvd = nblk_dvd;            div_dsr = DV_W'(blk_q); end
         ST_DEPTH:  begin div_dvd = DV_W'(sdep_q);       div_dsr = DV_W'(blk_q); end
         ST_STRIPE: begin div_dvd = lba_q;               div_dsr = width_q;      end
         ST_DISK:   begin div_dvd = off_q;               div_dsr = depth_q;      end
         default:   begin div_dvd = '0;                  div_dsr = '0;           end
      endcase
   end

   msm_divider #(.W(DV_W)) i_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (div_go_q),
      .dividend (div_dvd),
      .divisor  (div_dsr),
      .done     (div_done),
      .quot     (div_quot),
      .rem      (div_rem)
   );

   assign req_ready = (state_q == ST_IDLE);
   assign busy      = !req_ready;
   assign out_load  = (state_q == ST_DISK) && div_done;
   assign pri_id    = DID_W'(div_quot[DISK_W-1:0]);
   assign mir_id    = wr_q ? (pri_id + DID_W'(nd_q)) : '0;
   assign dblk_calc = sidx_q * depth_q + div_rem;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         div_go_q <= 1'b0;
         lba_q    <= '0;
         remain_q <= '0;
         depth_q  <= '0;
         width_q  <= '0;
         sidx_q   <= '0;
         off_q    <= '0;
         blk_q    <= '0;
         sdep_q   <= '0;
         len_q    <= '0;
         nd_q     <= '0;
         wr_q     <= 1'b0;
      end else begin
         div_go_q <= 1'b0;
         case (state_q)
            ST_IDLE: if (req_valid) begin
               lba_q    <= req_lba;
               len_q    <= req_len;
               wr_q     <= req_write;
               blk_q    <= cfg_blk_bytes;
               sdep_q   <= cfg_stripe_bytes;
               nd_q     <= cfg_ndisk;
               state_q  <= ST_NBLK;
               div_go_q <= 1'b1;
            end
            ST_NBLK: if (div_done) begin
               remain_q <= (div_quot == '0) ? LBA_W'(1) : div_quot;
               state_q  <= ST_DEPTH;
               div_go_q <= 1'b1;
            end
            ST_DEPTH: if (div_done) begin
               depth_q  <= div_quot;
               width_q  <= div_quot * DV_W'(nd_q);
               state_q  <= ST_STRIPE;
               div_go_q <= 1'b1;
            end
            ST_STRIPE: if (div_done) begin
               sidx_q   <= div_quot;
               off_q    <= div_rem;
               state_q  <= ST_DISK;
               div_go_q <= 1'b1;
            end
            ST_DISK: if (div_done) begin
               state_q  <= ST_EMIT;
            end
            ST_EMIT: if (out_fire) begin
               if (remain_q == LBA_W'(1)) begin
                  state_q <= ST_IDLE;
               end else begin
                  lba_q    <= lba_q + 1'b1;
                  remain_q <= remain_q - 1'b1;
                  state_q  <= ST_STRIPE;
                  div_go_q <= 1'b1;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   msm_out_stage #(.LBA_W(LBA_W), .DID_W(DID_W)) i_out (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (out_load),
      .in_lba     (lba_q),
      .in_pri     (pri_id),
      .in_dblk    (dblk_calc),
      .in_mir_en  (wr_q),
      .in_mir     (mir_id),
      .in_last    (remain_q == LBA_W'(1)),
      .out_ready  (out_ready),
      .out_valid  (out_valid),
      .out_lba    (out_lba),
      .out_pri    (out_pri_disk),
      .out_dblk   (out_dblk),
      .out_mir_en (out_mir_en),
      .out_mir    (out_mir_disk),
      .out_last   (out_last),
      .fire       (out_fire)
   );

   // Sequence tracker for the consecutive-block check
   logic             seq_pend_q;
   logic [LBA_W-1:0] seq_next_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seq_pend_q <= 1'b0;
         seq_next_q <= '0;
      end else if (out_fire) begin
         seq_pend_q <= !out_last;
         seq_next_q <= out_lba + 1'b1;
      end
   end

   // R1: each beat after the first follows its predecessor by one block
   a_r1_consecutive: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && seq_pend_q |-> out_lba == seq_next_q);

   // R2: taking the final beat returns the block to idle
   a_r2_last_idle: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_ready && out_last |=> req_ready);

   // R3: primary disk id lies below the captured disk count
   a_r3_disk_range: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> out_pri_disk < DID_W'(nd_q));

   // R5: mirror disk lies in the upper half of the array
   a_r5_mirror_range: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_mir_en |-> out_mir_disk >= DID_W'(nd_q));

   // R7: beats only appear while a request is in flight
   a_r7_valid_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> busy);

   // R9: captured configuration is frozen while busy
   a_r9_cfg_held: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(nd_q) && $stable(blk_q) && $stable(sdep_q));
endmodule

// File: tb/test_mstripe_mapper.sv
`timescale 1ns/1ps
module test_mstripe_mapper;
   localparam int LBA_W  = 32;
   localparam int LEN_W  = 24;
   localparam int DISK_W = 4;
   localparam int WDOG   = 150000;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [LEN_W-1:0]  cfg_blk_bytes = '0;
   logic [LEN_W-1:0]  cfg_stripe_bytes = '0;
   logic [DISK_W-1:0] cfg_ndisk = '0;
   logic              req_valid = 1'b0;
   logic              req_ready;
   logic [LBA_W-1:0]  req_lba = '0;
   logic [LEN_W-1:0]  req_len = '0;
   logic              req_write = 1'b0;
   logic              busy;
   logic              out_valid;
   logic              out_ready = 1'b0;
   logic [LBA_W-1:0]  out_lba;
   logic [DISK_W:0]   out_pri_disk;
   logic [LBA_W-1:0]  out_dblk;
   logic              out_mir_en;
   logic [DISK_W:0]   out_mir_disk;
   logic              out_last;

   int n_checks = 0;
   int n_fails  = 0;
   int cycles   = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   mstripe_mapper #(.LBA_W(LBA_W), .LEN_W(LEN_W), .DISK_W(DISK_W)) i_mstripe_mapper (
      .clk(clk), .rst_n(rst_n),
      .cfg_blk_bytes(cfg_blk_bytes), .cfg_stripe_bytes(cfg_stripe_bytes), .cfg_ndisk(cfg_ndisk),
      .req_valid(req_valid), .req_ready(req_ready), .req_lba(req_lba), .req_len(req_len),
      .req_write(req_write), .busy(busy),
      .out_valid(out_valid), .out_ready(out_ready), .out_lba(out_lba),
      .out_pri_disk(out_pri_disk), .out_dblk(out_dblk), .out_mir_en(out_mir_en),
      .out_mir_disk(out_mir_disk), .out_last(out_last)
   );

   // Stimulus table: start block, bytes, write, block bytes, stripe bytes, disks
   localparam int NV = 6;
   localparam longint V_LBA [NV] = '{21, 1000, 10, 0, 7, 123456};
   localparam longint V_LEN [NV] = '{4096, 24576, 20000, 0, 5000, 8192};
   localparam bit     V_WR  [NV] = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0};
   localparam longint V_BLK [NV] = '{4096, 8192, 4096, 4096, 512, 4096};
   localparam longint V_SD  [NV] = '{16384, 16384, 16384, 16384, 512, 65536};
   localparam longint V_ND  [NV] = '{3, 2, 3, 3, 4, 1};

   task automatic check(input string tag, input longint act, input longint exp);
      n_checks++;
      if (act != exp) begin
         n_fails++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic longint nblocks(input longint len, input longint blk);
      longint n;
      n = (len + blk - 1) / blk;
      return (n == 0) ? 1 : n;
   endfunction

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > WDOG) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
         finish_run();
      end
   end

   task automatic wait_valid();
      while (!out_valid) @(negedge clk);
   endtask

   task automatic submit(input longint lba, input longint len, input bit wr,
                         input longint blk, input longint sd, input longint nd);
      while (!req_ready) @(negedge clk);
      cfg_blk_bytes    = LEN_W'(blk);
      cfg_stripe_bytes = LEN_W'(sd);
      cfg_ndisk        = DISK_W'(nd);
      req_lba   = LBA_W'(lba);
      req_len   = LEN_W'(len);
      req_write = wr;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   // Checks one beat against the mapping rules and takes it
   task automatic take_beat(input longint lba, input bit wr, input bit last,
                            input longint blk, input longint sd, input longint nd);
      longint d, w, disk, dblk;
      wait_valid();
      d = sd / blk;
      w = d * nd;
      disk = (lba % w) / d;
      dblk = (lba / w) * d + ((lba % w) % d);
      check("R1 lba", out_lba, lba);
      check("R3 primary disk", out_pri_disk, disk);
      check("R4 disk block", out_dblk, dblk);
      check("R2 last flag", out_last, last);
      if (wr) begin
         check("R5 mirror enable", out_mir_en, 1);
         check("R5 mirror disk", out_mir_disk, disk + nd);
      end else begin
         check("R6 mirror enable", out_mir_en, 0);
         check("R6 mirror disk", out_mir_disk, 0);
      end
      out_ready = 1'b1;
      @(negedge clk);
      out_ready = 1'b0;
      if (last) check("R2 ready after last", req_ready, 1);
      else      check("R7 busy mid request", busy, 1);
   endtask

   task automatic run_vec(input longint lba, input longint len, input bit wr,
                          input longint blk, input longint sd, input longint nd);
      longint n;
      n = nblocks(len, blk);
      submit(lba, len, wr, blk, sd, nd);
      for (longint k = 0; k < n; k++)
         take_beat(lba + k, wr, (k == n - 1), blk, sd, nd);
   endtask

   initial begin
      // R10: reset state
      repeat (3) @(negedge clk);
      check("R10 req_ready in reset", req_ready, 1);
      check("R10 busy in reset", busy, 0);
      check("R10 out_valid in reset", out_valid, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R10 req_ready after reset", req_ready, 1);

      // Table-driven main function
      for (int v = 0; v < NV; v++)
         run_vec(V_LBA[v], V_LEN[v], V_WR[v], V_BLK[v], V_SD[v], V_ND[v]);

      // R4/R5: worked example directly
      submit(21, 4096, 1'b1, 4096, 16384, 3);
      wait_valid();
      check("R4 example disk block", out_dblk, 5);
      check("R5 example mirror disk", out_mir_disk, 5);
      take_beat(21, 1'b1, 1'b1, 4096, 16384, 3);

      // R8: backpressure holds the beat
      submit(40, 8192, 1'b1, 4096, 16384, 3);
      wait_valid();
      begin
         longint h_lba, h_dblk, h_pri;
         h_lba = out_lba; h_dblk = out_dblk; h_pri = out_pri_disk;
         for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            check("R8 valid held", out_valid, 1);
            check("R8 lba held", out_lba, h_lba);
            check("R8 dblk held", out_dblk, h_dblk);
            check("R8 disk held", out_pri_disk, h_pri);
         end
      end
      take_beat(40, 1'b1, 1'b0, 4096, 16384, 3);
      take_beat(41, 1'b1, 1'b1, 4096, 16384, 3);

      // R7/R9: new request and config change while busy are ignored
      submit(100, 8192, 1'b0, 4096, 16384, 3);
      cfg_ndisk = 4'd1;
      cfg_blk_bytes = 24'd512;
      req_lba = 32'd999;
      req_valid = 1'b1;
      check("R7 ready low while busy", req_ready, 0);
      take_beat(100, 1'b0, 1'b0, 4096, 16384, 3);
      wait_valid();
      req_valid = 1'b0;
      take_beat(101, 1'b0, 1'b1, 4096, 16384, 3);
      repeat (80) @(negedge clk);
      check("R7 no beat from ignored request", out_valid, 0);
      check("R7 idle after ignored request", busy, 0);

      // R10: reset mid request
      submit(300, 16384, 1'b1, 4096, 16384, 3);
      repeat (10) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check("R10 busy cleared by reset", busy, 0);
      check("R10 out_valid cleared by reset", out_valid, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R10 ready after mid reset", req_ready, 1);

      finish_run();
   end
endmodule